// File: doc/BRIEF.md
# Masked Sequential Status Read Port

This block lets a host read back a set of seven byte-wide status and read registers belonging to a DMA controller, one byte per read, over an 8-bit data output. A 7-bit enable mask chooses which registers take part. Each completed read strobe moves an internal pointer to the next enabled register in ascending index order. After the highest enabled register the pointer wraps back to the lowest enabled one. Registers whose mask bit is clear are skipped.

Two commands steer the sequence. An initiate command returns the pointer to the lowest enabled register. A status-only command makes the next read return the status byte (register 0) without disturbing the sequence pointer. The register contents come from outside. This block only selects among them.

Top module: `rdport_top`

## Requirements
- R1: After reset the mask is all zeros, the pointer is at register 0 and status-only mode is off, so `dataOut` shows the status byte (register 0).
- R2: A mask write (`maskWrEn` high for one cycle) stores `maskIn`, where bit i enables register i. Register i sits at `regsIn[8*i+7:8*i]` and register 0 is the status byte. The write moves the pointer to the lowest enabled register and cancels status-only mode. The effect shows from the next cycle.
- R3: While the mask is nonzero, the pointer only ever rests on a register whose mask bit is set.
- R4: A read completes when `rdStrobe` has been sampled high and is then sampled low. On that edge the pointer moves to the next enabled register above it, wrapping to the lowest enabled one, and `dataOut` shows the new register from that cycle on.
- R5: An initiate command (`cmdValid` high with `cmdStatusOnly` = 0) puts the pointer back on the lowest enabled register.
- R6: While the mask is all zeros, `dataOut` is the status byte and completed reads change nothing.
- R7: A status-only command (`cmdValid` high with `cmdStatusOnly` = 1) makes `dataOut` the status byte until the next completed read. That read does not move the pointer, and the following reads resume the sequence where it stood.
- R8: Without a completed read, a command or a mask write, the pointer holds its value.
- R9: `dataOut` follows changes on the selected register input in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| maskWrEn | input | 1 | Write strobe for the enable mask |
| maskIn | input | 7 | New enable mask, bit i for register i |
| cmdValid | input | 1 | Command strobe |
| cmdStatusOnly | input | 1 | Command kind: 1 selects status-only, 0 selects initiate sequence |
| rdStrobe | input | 1 | Read strobe; the read completes on its trailing edge |
| regsIn | input | 56 | Seven register bytes, register i at bits 8i+7:8i |
| dataOut | output | 8 | Byte currently presented to the bus |

## Verification
On every cycle, the assertions check three things: the pointer stays on an enabled register, a rewind or mask load lands on the lowest enabled bit, and the pointer holds when no strobe asks it to move. They also check that a status-only command or an all-zero mask routes the status byte to the output, and that status-only mode ends after one completed read. Only the bench scenarios can show the order of the read values: the wrap-around after the highest enabled register, the resumption of the sequence after a status-only read, and the output following a live register change.

// File: rtl/rdport_pkg.sv
package rdport_pkg;
  localparam int NUM_REGS = 7;
  localparam int DATA_W   = 8;

  typedef struct packed {
    logic loadMask;   // store a new mask, pointer to lowest enabled
    logic rewind;     // pointer to lowest enabled
    logic advance;    // pointer to next enabled
    logic statusSel;  // present status byte regardless of pointer
  } seqCtrl_t;
endpackage

// File: rtl/rdport_ctrl.sv
module rdport_ctrl
  import rdport_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     maskWrEn,
  input  logic     cmdValid,
  input  logic     cmdStatusOnly,
  input  logic     rdStrobe,
  output seqCtrl_t ctrl
);
  logic rdPrev;
  logic statusMode;
  logic readDone;

  assign readDone = rdPrev & ~rdStrobe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPrev     <= 1'b0;
      statusMode <= 1'b0;
    end else begin
      rdPrev <= rdStrobe;
      if (maskWrEn)      statusMode <= 1'b0;
      else if (cmdValid) statusMode <= cmdStatusOnly;
      else if (readDone) statusMode <= 1'b0;
    end
  end

  // priority: mask write, then command, then completed read
  always_comb begin
    ctrl.loadMask  = maskWrEn;
    ctrl.rewind    = ~maskWrEn & cmdValid & ~cmdStatusOnly;
    ctrl.advance   = ~maskWrEn & ~cmdValid & readDone & ~statusMode;
    ctrl.statusSel = statusMode;
  end

  AST_STATUS_ONE_READ: assert property (@(posedge clk) disable iff (!rstN)
    (statusMode && readDone && !maskWrEn && !cmdValid) |=> !statusMode); // R7
endmodule

// File: rtl/rdport_datapath.sv
module rdport_datapath
  import rdport_pkg::*;
#(
  parameter int N_REGS = NUM_REGS,
  parameter int BYTE_W = DATA_W,
  localparam int PTR_W = $clog2(N_REGS)
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  seqCtrl_t                 ctrl,
  input  logic [N_REGS-1:0]        maskIn,
  input  logic [N_REGS*BYTE_W-1:0] regsIn,
  output logic [BYTE_W-1:0]        dataOut
);
  logic [N_REGS-1:0] mask;
  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  nextPtr;
  logic [PTR_W-1:0]  firstOfMask;
  logic [PTR_W-1:0]  firstOfIn;

  function automatic logic [PTR_W-1:0] lowestSet(input logic [N_REGS-1:0] m);
    logic [PTR_W-1:0] r;
    r = '0;
    for (int i = N_REGS - 1; i >= 0; i--)
      if (m[i]) r = PTR_W'(i);
    return r;
  endfunction

  always_comb begin
    firstOfMask = lowestSet(mask);
    firstOfIn   = lowestSet(maskIn);
    nextPtr     = ptr;
    // scan downward so the nearest enabled register above ptr wins
    for (int k = N_REGS - 1; k >= 1; k--) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= N_REGS) idx = idx - N_REGS;
      if (mask[idx]) nextPtr = PTR_W'(idx);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mask <= '0;
      ptr  <= '0;
    end else if (ctrl.loadMask) begin
      mask <= maskIn;
      ptr  <= firstOfIn;
    end else if (ctrl.rewind) begin
      ptr  <= firstOfMask;
    end else if (ctrl.advance) begin
      ptr  <= nextPtr;
    end
  end

  always_comb begin
    if (ctrl.statusSel || mask == '0)
      dataOut = regsIn[BYTE_W-1:0];
    else
      dataOut = regsIn[int'(ptr)*BYTE_W +: BYTE_W];
  end

  AST_PTR_ON_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (mask != '0) |-> mask[ptr]); // R3

  AST_REWIND_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.rewind || ctrl.loadMask) |->
      ((mask & ((N_REGS'(1) << ptr) - N_REGS'(1))) == '0)); // R5

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrl.rewind || ctrl.loadMask || ctrl.advance) |-> $stable(ptr)); // R8
endmodule

// File: rtl/rdport_top.sv
module rdport_top
  import rdport_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       maskWrEn,
  input  logic [NUM_REGS-1:0]        maskIn,
  input  logic                       cmdValid,
  input  logic                       cmdStatusOnly,
  input  logic                       rdStrobe,
  input  logic [NUM_REGS*DATA_W-1:0] regsIn,
  output logic [DATA_W-1:0]          dataOut
);
  seqCtrl_t ctrl;

  rdport_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .maskWrEn(maskWrEn), .cmdValid(cmdValid),
    .cmdStatusOnly(cmdStatusOnly), .rdStrobe(rdStrobe), .ctrl(ctrl)
  );

  rdport_datapath #(.N_REGS(NUM_REGS), .BYTE_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .maskIn(maskIn),
    .regsIn(regsIn), .dataOut(dataOut)
  );

  AST_STATUS_CMD_OUT: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmdValid && cmdStatusOnly && !maskWrEn) |-> dataOut == regsIn[DATA_W-1:0]); // R7

  AST_ZERO_MASK_OUT: assert property (@(posedge clk) disable iff (!rstN)
    $past(maskWrEn && maskIn == '0) |-> dataOut == regsIn[DATA_W-1:0]); // R6
endmodule

// File: tb/tb_rdport_top.sv
module tb_rdport_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic maskWrEn = 1'b0;
  logic [6:0] maskIn = '0;
  logic cmdValid = 1'b0;
  logic cmdStatusOnly = 1'b0;
  logic rdStrobe = 1'b0;
  logic [55:0] regsIn;
  logic [7:0] dataOut;

  always #5 clk = ~clk;

  rdport_top dut (.*);

  typedef struct { logic [7:0] val; string req; } exp_t;
  exp_t q[$];
  int nChecks = 0;
  int nFails = 0;

  logic [7:0] regs [7];
  logic [6:0] mMask = '0;
  int mPtr = 0;
  bit mStat = 0;

  always_comb for (int i = 0; i < 7; i++) regsIn[8*i +: 8] = regs[i];

  function automatic int firstOf(logic [6:0] m);
    for (int i = 0; i < 7; i++) if (m[i]) return i;
    return 0;
  endfunction

  function automatic int nextOf(logic [6:0] m, int p);
    for (int k = 1; k <= 7; k++) if (m[(p + k) % 7]) return (p + k) % 7;
    return p;
  endfunction

  task automatic check(logic [7:0] act, logic [7:0] exp, string req);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: dataOut=%h expected %h", req, act, exp);
    end
  endtask

  task automatic writeMask(logic [6:0] m);
    @(negedge clk); #1 maskWrEn = 1'b1; maskIn = m;
    @(negedge clk); #1 maskWrEn = 1'b0;
    mMask = m; mPtr = firstOf(m); mStat = 0;
  endtask

  task automatic sendCmd(bit statusOnly);
    @(negedge clk); #1 cmdValid = 1'b1; cmdStatusOnly = statusOnly;
    @(negedge clk); #1 cmdValid = 1'b0;
    if (statusOnly) mStat = 1;
    else begin mStat = 0; mPtr = firstOf(mMask); end
  endtask

  // driver: push expected byte, then perform one read
  task automatic doRead(string req);
    exp_t e;
    e.val = (mStat || mMask == '0) ? regs[0] : regs[mPtr];
    e.req = req;
    q.push_back(e);
    @(negedge clk); #1 rdStrobe = 1'b1;
    @(negedge clk); #1 rdStrobe = 1'b0;
    if (mStat) mStat = 0;
    else if (mMask != '0) mPtr = nextOf(mMask, mPtr);
  endtask

  // monitor: compare while the strobe is high
  always @(negedge clk) begin
    if (rdStrobe) begin
      if (q.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL monitor: read with no expected item, dataOut=%h expected none", dataOut);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(dataOut, e.val, e.req);
      end
    end
  end

  initial begin
    #1_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) regs[i] = 8'hA0 + 8'(i * 17);
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #2;
    check(dataOut, regs[0], "R1 reset shows status");

    writeMask(7'h7F);
    for (int i = 0; i < 8; i++) doRead("R4 full mask with wrap");

    writeMask(7'b0101010);
    for (int i = 0; i < 4; i++) doRead("R3 skip disabled registers");

    doRead("R5 before initiate");
    sendCmd(1'b0);
    doRead("R5 after initiate");

    sendCmd(1'b1);
    doRead("R7 status-only read");
    doRead("R7 sequence resumes");

    repeat (5) @(negedge clk);
    doRead("R8 pointer held while idle");

    @(negedge clk); #1 regs[mPtr] = 8'h5C;
    #2 check(dataOut, 8'h5C, "R9 live register follows");

    writeMask(7'h00);
    doRead("R6 zero mask status");
    doRead("R6 zero mask status again");

    writeMask(7'b1000000);
    doRead("R2 single enabled register");
    doRead("R2 single enabled register wrap");

    sendCmd(1'b1);
    writeMask(7'b0000110);
    doRead("R2 mask write cancels status-only");
    doRead("R2 next enabled after lowest");

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule